// File: doc/BRIEF.md
# Low-Power State Controller for a DDR Memory Model

This block tracks the clock-enable power state of a low-power DDR memory device model. On every rising clock it compares the clock-enable level with the level it held at the previous edge. When clock-enable falls, it reads the command pins (chip select, row strobe, column strobe, write enable) to decide which low-power state to enter. A plain no-operation or a deselect gives power down. One refresh-type encoding gives self refresh. One write-enable-only encoding gives deep power down. Self refresh and deep power down also need an "all banks idle" report from the bank tracker.

Each low-power state lasts as long as clock-enable stays low and ends when it returns high. After power down or self refresh, the command qualifiers stay low for a programmable exit delay. Leaving deep power down loses the array contents, so the machine goes back to an uninitialized state that only the initialization sequence can leave. An illegal entry attempt is refused and reported by a one-cycle error pulse. This includes a clock-enable drop during an open data burst.

Top module: `lp_power_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is uninitialized: `pstate` = 0, and `cmd_ok`, `rd_ok`, `err` and `sref_on` are all 0.
- R2: In the uninitialized state, `init_done` high with `cke` high moves the state to normal (`pstate` = 1) at that edge. A clock-enable fall in the uninitialized state gives a one-cycle `err` and leaves the state unchanged.
- R3: In the normal state, a clock-enable fall (`cke` 1 at the previous edge, 0 at this one) enters power down (`pstate` = 2) at that edge if the pins show a deselect (`cs_n` = 1) or a no-operation (`cs_n`,`ras_n`,`cas_n`,`we_n` = 0,1,1,1).
- R4: A clock-enable fall with pins 0,0,0,1 and `banks_idle` high enters self refresh (`pstate` = 3, `sref_on` = 1). The same fall with `banks_idle` low is refused with `err`.
- R5: A clock-enable fall with pins 0,1,1,0 and `banks_idle` high enters deep power down (`pstate` = 4). The same fall with `banks_idle` low is refused with `err`.
- R6: A clock-enable fall while `burst_open` is high, or with any other pin encoding, gives `err` high for exactly one cycle and leaves the state at normal. The burst check takes priority over every encoding.
- R7: A low-power state holds while `cke` stays low, whatever the command pins show. `sref_on` is high only in self refresh, so it stays low in power down.
- R8: When `cke` rises in power down, the state returns to normal at that edge. `cmd_ok` and `rd_ok` then stay low for PD_EXIT_CYC cycles (default 1).
- R9: When `cke` rises in self refresh, the state returns to normal at that edge. `rd_ok` is high at once, and `cmd_ok` stays low for SREF_EXIT_CYC cycles (default 12).
- R10: When `cke` rises in deep power down, the state becomes uninitialized (`pstate` = 0) and `cmd_ok` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable level at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | All banks precharged / idle |
| burst_open | input | 1 | A read or write burst is in progress |
| init_done | input | 1 | Initialization sequence finished |
| pstate | output | 3 | 0 uninit, 1 normal, 2 power down, 3 self refresh, 4 deep power down |
| cmd_ok | output | 1 | Any command may be issued |
| rd_ok | output | 1 | A read may be issued |
| err | output | 1 | One-cycle pulse on a refused entry |
| sref_on | output | 1 | Internal self refresh running |

## Verification
A wrong state register shows on `pstate` right after the entry edge. One clock is enough to tell a refused entry, which pulses `err` and keeps code 1, from an accepted one. A wrong clock-enable history shows up as a missing entry or a spurious exit on the first edge of a new level. A miscounted exit delay shows on `cmd_ok` as an early or late rise, measured from the exit edge. The bench tries every pin encoding with both idle and burst settings, then runs the matching exit, so each of these faults appears within a few cycles of the entry or exit under test.

// File: rtl/lp_pwr_pkg.sv
package lp_pwr_pkg;

  typedef enum logic [2:0] {
    PS_UNINIT = 3'd0,
    PS_NORMAL = 3'd1,
    PS_PDN    = 3'd2,
    PS_SREF   = 3'd3,
    PS_DPD    = 3'd4
  } pstate_t;

  typedef enum logic [1:0] {
    EN_PDN  = 2'd0,
    EN_SREF = 2'd1,
    EN_DPD  = 2'd2,
    EN_BAD  = 2'd3
  } entry_t;

endpackage

// File: rtl/lp_entry_decode.sv
module lp_entry_decode
  import lp_pwr_pkg::*;
(
  input  logic   cs_n,
  input  logic   ras_n,
  input  logic   cas_n,
  input  logic   we_n,
  input  logic   banks_idle,
  input  logic   burst_open,
  output entry_t entry
);

  // Classifies the pins seen on a clock-enable fall.
  always_comb begin
    if (burst_open) begin
      entry = EN_BAD;
    end else if (cs_n) begin
      entry = EN_PDN;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  entry = EN_PDN;
        3'b001:  entry = banks_idle ? EN_SREF : EN_BAD;
        3'b110:  entry = banks_idle ? EN_DPD  : EN_BAD;
        default: entry = EN_BAD;
      endcase
    end
  end

endmodule

// File: rtl/lp_exit_timer.sv
module lp_exit_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  // R8 R9: a load is always followed by a visible count.
  assert_load_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> busy);

endmodule

// File: rtl/lp_power_ctrl.sv
module lp_power_ctrl
  import lp_pwr_pkg::*;
#(
  parameter int SREF_EXIT_CYC = 12,
  parameter int PD_EXIT_CYC   = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  input  logic       burst_open,
  input  logic       init_done,
  output logic [2:0] pstate,
  output logic       cmd_ok,
  output logic       rd_ok,
  output logic       err,
  output logic       sref_on
);

  localparam int MAX_CYC = (SREF_EXIT_CYC > PD_EXIT_CYC) ? SREF_EXIT_CYC : PD_EXIT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SREF_LD = CNT_W'(SREF_EXIT_CYC);
  localparam logic [CNT_W-1:0] PD_LD   = CNT_W'(PD_EXIT_CYC);

  pstate_t          state_q, state_d;
  logic             cke_q;
  logic             err_q, err_d;
  logic             sref_x_q, sref_x_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             busy;
  entry_t           entry;
  logic             cke_fall, cke_rise;

  lp_entry_decode u_dec (
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .banks_idle (banks_idle),
    .burst_open (burst_open),
    .entry      (entry)
  );

  lp_exit_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .busy     (busy)
  );

  assign cke_fall = cke_q & ~cke;
  assign cke_rise = ~cke_q & cke;

  always_comb begin
    state_d  = state_q;
    err_d    = 1'b0;
    ld       = 1'b0;
    ld_val   = '0;
    sref_x_d = sref_x_q;
    unique case (state_q)
      PS_UNINIT: begin
        if (cke_fall)              err_d   = 1'b1;
        else if (init_done && cke) state_d = PS_NORMAL;
      end
      PS_NORMAL: begin
        if (cke_fall) begin
          unique case (entry)
            EN_PDN:  state_d = PS_PDN;
            EN_SREF: state_d = PS_SREF;
            EN_DPD:  state_d = PS_DPD;
            default: err_d   = 1'b1;
          endcase
        end
      end
      PS_PDN: begin
        if (cke_rise) begin
          state_d  = PS_NORMAL;
          ld       = 1'b1;
          ld_val   = PD_LD;
          sref_x_d = 1'b0;
        end
      end
      PS_SREF: begin
        if (cke_rise) begin
          state_d  = PS_NORMAL;
          ld       = 1'b1;
          ld_val   = SREF_LD;
          sref_x_d = 1'b1;
        end
      end
      PS_DPD: begin
        if (cke_rise) state_d = PS_UNINIT;
      end
      default: state_d = PS_UNINIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PS_UNINIT;
      cke_q    <= 1'b0;
      err_q    <= 1'b0;
      sref_x_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cke_q    <= cke;
      err_q    <= err_d;
      sref_x_q <= sref_x_d;
    end
  end

  assign pstate  = state_q;
  assign err     = err_q;
  assign sref_on = (state_q == PS_SREF);
  assign cmd_ok  = (state_q == PS_NORMAL) && !busy;
  assign rd_ok   = (state_q == PS_NORMAL) && (!busy || sref_x_q);

  // R6: a refused entry never moves the state.
  assert_err_keeps_state_R6: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (state_q == $past(state_q)));

  // R4: self refresh only begins from normal with idle banks.
  assert_sref_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == PS_SREF) |-> $past(state_q == PS_NORMAL && banks_idle && !burst_open));

  // R7: low-power states hold while clock-enable stays low.
  assert_hold_low_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {PS_PDN, PS_SREF, PS_DPD} && !cke) |=> (state_q == $past(state_q)));

  // R10: deep power down exits only to uninitialized.
  assert_dpd_exit_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == PS_DPD && state_q != PS_DPD) |-> (state_q == PS_UNINIT));

  // R9: first cycle after self refresh exit allows reads only.
  assert_sref_exit_block_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == PS_SREF && state_q == PS_NORMAL) |-> (!cmd_ok && rd_ok));

  // R5: deep power down needs idle banks.
  assert_dpd_entry_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == PS_DPD) |-> $past(banks_idle && !burst_open));

endmodule

// File: tb/lp_power_ctrl_tb_top.sv
`timescale 1ns/1ps
module lp_power_ctrl_tb_top;

  localparam int SREF_N = 12;
  localparam int PD_N   = 1;

  logic clk = 1'b0;
  logic rst, cke, cs_n, ras_n, cas_n, we_n, banks_idle, burst_open, init_done;
  logic [2:0] pstate;
  logic cmd_ok, rd_ok, err, sref_on;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lp_power_ctrl #(.SREF_EXIT_CYC(SREF_N), .PD_EXIT_CYC(PD_N)) dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .banks_idle(banks_idle), .burst_open(burst_open),
    .init_done(init_done), .pstate(pstate), .cmd_ok(cmd_ok), .rd_ok(rd_ok),
    .err(err), .sref_on(sref_on)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pins(input logic [3:0] c);
    {cs_n, ras_n, cas_n, we_n} = c;
  endtask

  function automatic int exp_state(input logic [3:0] c, input logic idle, input logic brst);
    if (brst)                         return 1;
    if (c[3] || c[2:0] == 3'b111)     return 2;
    if (c[2:0] == 3'b001)             return idle ? 3 : 1;
    if (c[2:0] == 3'b110)             return idle ? 4 : 1;
    return 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cke = 1'b0; pins(4'hF); banks_idle = 1'b0;
    burst_open = 1'b0; init_done = 1'b0;
    @(negedge clk);
    tick(); tick();
    chk("R1 pstate", pstate, 0);
    chk("R1 cmd_ok", cmd_ok, 0);
    chk("R1 rd_ok", rd_ok, 0);
    chk("R1 err", err, 0);
    chk("R1 sref_on", sref_on, 0);
    rst = 1'b0;

    // R2: fall while uninitialized is refused
    cke = 1'b1; tick();
    cke = 1'b0; tick();
    chk("R2 err on fall", err, 1);
    chk("R2 state kept", pstate, 0);
    tick();
    chk("R2 err pulse", err, 0);
    cke = 1'b1; tick();
    chk("R2 still uninit", pstate, 0);
    init_done = 1'b1; tick();
    init_done = 1'b0;
    chk("R2 init to normal", pstate, 1);
    chk("R2 cmd_ok", cmd_ok, 1);

    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < 2; i++) begin
        for (int b = 0; b < 2; b++) begin
          int es;
          int n;
          es = exp_state(4'(c), i[0], b[0]);
          cke = 1'b1; pins(4'hE); banks_idle = 1'b0; burst_open = 1'b0;
          tick();
          cke = 1'b0; pins(4'(c)); banks_idle = i[0]; burst_open = b[0];
          tick();
          chk((es == 2) ? "R3 entry" : (es == 3) ? "R4 entry" :
              (es == 4) ? "R5 entry" : "R6 refuse", pstate, es);
          chk("R6 err", err, (es == 1) ? 1 : 0);
          chk("R7 sref_on", sref_on, (es == 3) ? 1 : 0);
          // junk pins with cke still low
          pins(4'(c) ^ 4'hF); banks_idle = 1'b1; burst_open = 1'b0;
          tick();
          chk("R7 held", pstate, es);
          chk("R6 err one cycle", err, 0);
          pins(4'hE);
          cke = 1'b1; tick();
          case (es)
            2: begin
              chk("R8 exit state", pstate, 1);
              chk("R8 rd_ok low", rd_ok, 0);
              n = 0;
              while (!cmd_ok && n < 40) begin tick(); n++; end
              chk("R8 exit delay", n, PD_N);
            end
            3: begin
              chk("R9 exit state", pstate, 1);
              chk("R9 rd_ok at once", rd_ok, 1);
              n = 0;
              while (!cmd_ok && n < 40) begin tick(); n++; end
              chk("R9 exit delay", n, SREF_N);
            end
            4: begin
              chk("R10 exit state", pstate, 0);
              chk("R10 cmd_ok low", cmd_ok, 0);
              init_done = 1'b1; tick(); init_done = 1'b0;
              chk("R2 reinit", pstate, 1);
            end
            default: begin
              chk("R6 normal after refuse", pstate, 1);
              chk("R6 cmd_ok", cmd_ok, 1);
            end
          endcase
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule